// File: doc/BRIEF.md
# GPIO Edge Interrupt Aggregator

This block is the interrupt half of a banked general-purpose I/O controller. It watches a vector of pin levels that have already been synchronized to its clock. For each pin it can look for a rising transition, a falling transition, both, or neither. Each transition it is set to look for latches a bit in a 32-bit status word, one word for every group of 32 pins.

Software arms edges through separate write-one-to-set and write-one-to-clear commands for each edge type. It acknowledges events by writing ones to the status word. Each status word drives two interrupt lines: one for its low 16 pins and one for its high 16 pins. Each line has its own bit in a bank-enable register. The lowest-numbered pins also drive a raw per-pin interrupt, for an interrupt controller that takes pin interrupts directly.

All outputs are registered. Reset is synchronous and active high.

Top module: `gpio_edge_irq`

## Requirements
- R1: Command codes on `wr_op` (used when `wr_en` is 1, applied to register set `wr_set`): 1 sets rising enables, 2 clears rising enables, 3 sets falling enables, 4 clears falling enables, 5 clears status bits, 6 loads the bank-enable register from `wr_data[NUM_BANKS-1:0]` (`wr_set` is ignored), and 0 does nothing. Codes 1 to 4 change only the bits where `wr_data` is 1.
- R2: A pin with both edge enables set raises its status bit on either transition. A pin with neither enable set never raises status.
- R3: A status-clear write clears exactly the bits written as 1 in the addressed set. Every other status bit keeps its value.
- R4: If an enabled edge and a clear of the same status bit fall in the same cycle, the bit stays set.
- R5: Bank k reads register set k/2. An even k uses status bits 15:0 and an odd k uses bits 31:16, so bank k covers pins 16k to 16k+15.
- R6: `bank_irq[k]` is a level that is 1 exactly when, one cycle earlier, any status bit of bank k was set and bank-enable bit k was 1.
- R7: For each pin p below DIRECT_PINS, `direct_irq[p]` pulses high for one cycle, in the cycle after the pin's level differs from its previous sample in an enabled direction.
- R8: Reset clears every edge enable, every status bit, the bank-enable register and all outputs. It also samples the current pin levels, so a pin that is held high across reset does not produce an edge.
- R9: An edge is found by comparing the pin's level with its level in the previous cycle. The status bit is set at the first clock edge that sees the new level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_sync | input | NUM_SETS*WORD_W | Synchronized pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_op | input | 3 | Write command code (see R1) |
| wr_set | input | SET_W | Register set addressed by the write |
| wr_data | input | WORD_W | Write data, one bit per pin or per bank |
| bank_irq | output | 2*NUM_SETS | Per-bank interrupt levels |
| direct_irq | output | DIRECT_PINS | Per-pin raw edge pulses for the low pins |

## Verification
The bench builds the block with two register sets and eight direct pins. With four banks, both halves of both status words can be checked, so the mapping from bank to set and half is exercised without a long pin vector. Eight direct pins put pin 16 and pin 63 outside the direct range. The test can then show that an edge on those pins reaches a bank line but does not produce a direct pulse.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam logic [2:0] OP_NONE     = 3'd0;
  localparam logic [2:0] OP_RISE_SET = 3'd1;
  localparam logic [2:0] OP_RISE_CLR = 3'd2;
  localparam logic [2:0] OP_FALL_SET = 3'd3;
  localparam logic [2:0] OP_FALL_CLR = 3'd4;
  localparam logic [2:0] OP_STAT_CLR = 3'd5;
  localparam logic [2:0] OP_BANK_EN  = 3'd6;
endpackage

// File: rtl/gpio_edge_det.sv
module gpio_edge_det #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] pin,
  input  logic              sel,
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] hit
);
  import gpio_irq_pkg::*;

  logic [WORD_W-1:0] rise_en_q, fall_en_q, prev_q;

  always_ff @(posedge clk) begin
    prev_q <= pin;
    if (rst) begin
      rise_en_q <= '0;
      fall_en_q <= '0;
    end else if (sel) begin
      case (op)
        OP_RISE_SET: rise_en_q <= rise_en_q | data;
        OP_RISE_CLR: rise_en_q <= rise_en_q & ~data;
        OP_FALL_SET: fall_en_q <= fall_en_q | data;
        OP_FALL_CLR: fall_en_q <= fall_en_q & ~data;
        default: ;
      endcase
    end
  end

  always_comb begin
    hit = (rise_en_q & pin & ~prev_q) | (fall_en_q & ~pin & prev_q);
  end
endmodule

// File: rtl/gpio_stat_w1c.sv
module gpio_stat_w1c #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] hit,
  input  logic [WORD_W-1:0] clr,
  output logic [WORD_W-1:0] stat
);
  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~clr) | hit;
  end
endmodule

// File: rtl/gpio_bank_gate.sv
module gpio_bank_gate #(
  parameter int NUM_SETS = 5,
  parameter int WORD_W   = 32,
  localparam int HALF_W    = WORD_W / 2,
  localparam int NUM_BANKS = 2 * NUM_SETS,
  localparam int NPINS     = NUM_SETS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPINS-1:0]     stat,
  input  logic                 en_we,
  input  logic [NUM_BANKS-1:0] en_data,
  output logic [NUM_BANKS-1:0] bank_en,
  output logic [NUM_BANKS-1:0] bank_irq
);
  always_ff @(posedge clk) begin
    if (rst)        bank_en <= '0;
    else if (en_we) bank_en <= en_data;
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) bank_irq[b] <= 1'b0;
      else     bank_irq[b] <= bank_en[b] & (|stat[b*HALF_W +: HALF_W]);
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NUM_SETS    = 5,
  parameter int WORD_W      = 32,
  parameter int DIRECT_PINS = 16,
  localparam int NPINS     = NUM_SETS * WORD_W,
  localparam int NUM_BANKS = 2 * NUM_SETS,
  localparam int SET_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NPINS-1:0]       pin_sync,
  input  logic                   wr_en,
  input  logic [2:0]             wr_op,
  input  logic [SET_W-1:0]       wr_set,
  input  logic [WORD_W-1:0]      wr_data,
  output logic [NUM_BANKS-1:0]   bank_irq,
  output logic [DIRECT_PINS-1:0] direct_irq
);
  import gpio_irq_pkg::*;

  logic [NPINS-1:0]     hit_vec;
  logic [NPINS-1:0]     clr_vec;
  logic [NPINS-1:0]     stat_vec;
  logic [NUM_BANKS-1:0] bank_en;
  logic                 bank_we;

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic set_sel;
    assign set_sel = wr_en && (wr_set == SET_W'(s));
    assign clr_vec[s*WORD_W +: WORD_W] =
      (set_sel && wr_op == OP_STAT_CLR) ? wr_data : '0;

    gpio_edge_det #(.WORD_W(WORD_W)) u_det (
      .clk  (clk),
      .rst  (rst),
      .pin  (pin_sync[s*WORD_W +: WORD_W]),
      .sel  (set_sel),
      .op   (wr_op),
      .data (wr_data),
      .hit  (hit_vec[s*WORD_W +: WORD_W])
    );

    gpio_stat_w1c #(.WORD_W(WORD_W)) u_stat (
      .clk  (clk),
      .rst  (rst),
      .hit  (hit_vec[s*WORD_W +: WORD_W]),
      .clr  (clr_vec[s*WORD_W +: WORD_W]),
      .stat (stat_vec[s*WORD_W +: WORD_W])
    );
  end

  assign bank_we = wr_en && (wr_op == OP_BANK_EN);

  gpio_bank_gate #(.NUM_SETS(NUM_SETS), .WORD_W(WORD_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .stat     (stat_vec),
    .en_we    (bank_we),
    .en_data  (wr_data[NUM_BANKS-1:0]),
    .bank_en  (bank_en),
    .bank_irq (bank_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) direct_irq <= '0;
    else     direct_irq <= hit_vec[DIRECT_PINS-1:0];
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NPINS       = 160,
  parameter int NUM_BANKS   = 10,
  parameter int DIRECT_PINS = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic [NUM_BANKS-1:0]   bank_irq,
  input logic [DIRECT_PINS-1:0] direct_irq,
  input logic [NPINS-1:0]       stat_vec,
  input logic [NPINS-1:0]       hit_vec,
  input logic [NPINS-1:0]       clr_vec,
  input logic [NUM_BANKS-1:0]   bank_en
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (bank_irq == '0 && direct_irq == '0)); // R8

  AST_STAT_ONLY_W1C: assert property (@(posedge clk) disable iff (rst)
    (($past(stat_vec) & ~stat_vec & ~$past(clr_vec)) == '0)); // R3

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
    ((stat_vec & $past(hit_vec)) == $past(hit_vec))); // R4

  AST_DIRECT_HAS_STAT: assert property (@(posedge clk) disable iff (rst)
    ((direct_irq & ~stat_vec[DIRECT_PINS-1:0]) == '0)); // R7

  AST_BANK_GATED: assert property (@(posedge clk) disable iff (rst)
    ((bank_irq & ~$past(bank_en)) == '0)); // R6
endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NPINS(NPINS), .NUM_BANKS(NUM_BANKS), .DIRECT_PINS(DIRECT_PINS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bank_irq   (bank_irq),
  .direct_irq (direct_irq),
  .stat_vec   (stat_vec),
  .hit_vec    (hit_vec),
  .clr_vec    (clr_vec),
  .bank_en    (bank_en)
);

// File: tb/gpio_edge_irq_tb.sv
module gpio_edge_irq_tb;
  localparam int NUM_SETS = 2;
  localparam int WORD_W   = 32;
  localparam int DIRECT   = 8;
  localparam int NPINS    = NUM_SETS * WORD_W;
  localparam int NB       = 2 * NUM_SETS;

  typedef struct packed {
    logic [2:0]  op;
    logic        set;
    logic [31:0] data;
    logic [63:0] pins;
    logic [3:0]  exp_bank;
    logic [7:0]  exp_dir;
  } vec_t;

  localparam int NVEC = 22;
  // Codes: 0 none, 1 rise set, 2 rise clr, 3 fall set, 4 fall clr, 5 stat clr, 6 bank en
  localparam vec_t VECS [NVEC] = '{
    '{3'd6, 1'b0, 32'h0000_000F, 64'h0,                    4'h0, 8'h00}, // R1 bank en
    '{3'd1, 1'b0, 32'h0001_0003, 64'h0,                    4'h0, 8'h00}, // R1 rise 0,1,16
    '{3'd3, 1'b0, 32'h0000_0002, 64'h0,                    4'h0, 8'h00}, // R1 fall 1
    '{3'd0, 1'b0, 32'h0,         64'h0000_0000_0001_0001,  4'h0, 8'h01}, // R9 R7 rises
    '{3'd0, 1'b0, 32'h0,         64'h0000_0000_0001_0001,  4'h3, 8'h00}, // R5 R6 both halves
    '{3'd5, 1'b0, 32'h0000_0001, 64'h0000_0000_0001_0001,  4'h3, 8'h00}, // R3 clear bit0
    '{3'd0, 1'b0, 32'h0,         64'h0000_0000_0001_0001,  4'h2, 8'h00}, // R3 bit16 kept
    '{3'd0, 1'b0, 32'h0,         64'h0000_0000_0001_0002,  4'h2, 8'h02}, // R2 pin0 fall ignored
    '{3'd0, 1'b0, 32'h0,         64'h0000_0000_0001_0000,  4'h3, 8'h02}, // R2 pin1 fall
    '{3'd5, 1'b0, 32'h0000_0002, 64'h0000_0000_0001_0002,  4'h3, 8'h02}, // R4 edge vs clear
    '{3'd0, 1'b0, 32'h0,         64'h0000_0000_0001_0002,  4'h3, 8'h00}, // R4 bit kept
    '{3'd6, 1'b0, 32'h0000_0001, 64'h0000_0000_0001_0002,  4'h3, 8'h00}, // R6 old enable
    '{3'd0, 1'b0, 32'h0,         64'h0000_0000_0001_0002,  4'h1, 8'h00}, // R6 bank1 masked
    '{3'd5, 1'b0, 32'hFFFF_FFFF, 64'h0000_0000_0001_0002,  4'h1, 8'h00}, // R3 clear all
    '{3'd0, 1'b0, 32'h0,         64'h0000_0000_0001_0002,  4'h0, 8'h00}, // R3 empty
    '{3'd1, 1'b1, 32'h8000_0000, 64'h0000_0000_0001_0002,  4'h0, 8'h00}, // R1 set1 pin63
    '{3'd6, 1'b0, 32'h0000_0008, 64'h0000_0000_0001_0002,  4'h0, 8'h00}, // R6 bank3 only
    '{3'd0, 1'b0, 32'h0,         64'h8000_0000_0001_0002,  4'h0, 8'h00}, // R5 pin63 rise
    '{3'd0, 1'b0, 32'h0,         64'h8000_0000_0001_0002,  4'h8, 8'h00}, // R5 bank3
    '{3'd2, 1'b1, 32'h8000_0000, 64'h0000_0000_0001_0002,  4'h8, 8'h00}, // R1 rise clr
    '{3'd5, 1'b1, 32'h8000_0000, 64'h8000_0000_0001_0002,  4'h8, 8'h00}, // R1 disabled rise
    '{3'd0, 1'b0, 32'h0,         64'h8000_0000_0001_0002,  4'h0, 8'h00}  // R1 stays clear
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NPINS-1:0] pin_sync = '0;
  logic             wr_en = 1'b0;
  logic [2:0]       wr_op = '0;
  logic             wr_set = 1'b0;
  logic [31:0]      wr_data = '0;
  logic [NB-1:0]    bank_irq;
  logic [DIRECT-1:0] direct_irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  gpio_edge_irq #(.NUM_SETS(NUM_SETS), .WORD_W(WORD_W), .DIRECT_PINS(DIRECT)) u_dut (
    .clk(clk), .rst(rst), .pin_sync(pin_sync), .wr_en(wr_en), .wr_op(wr_op),
    .wr_set(wr_set), .wr_data(wr_data), .bank_irq(bank_irq), .direct_irq(direct_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic set, input logic [31:0] data,
                       input logic [63:0] pins);
    wr_en   = (op != 3'd0);
    wr_op   = op;
    wr_set  = set;
    wr_data = data;
    pin_sync = pins;
    @(negedge clk);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 reset bank lines", 32'(bank_irq), 32'h0);
    chk("R8 reset direct", 32'(direct_irq), 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].op, VECS[i].set, VECS[i].data, VECS[i].pins);
      chk($sformatf("R6 bank lines vec %0d", i), 32'(bank_irq), 32'(VECS[i].exp_bank));
      chk($sformatf("R7 direct vec %0d", i), 32'(direct_irq), 32'(VECS[i].exp_dir));
    end

    // R8: pins held high across reset give no edge afterwards
    pin_sync = '1;
    wr_en = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R8 enables cleared", 32'(bank_irq), 32'h0);
    drive(3'd6, 1'b0, 32'h0000_000F, '1);
    drive(3'd1, 1'b0, 32'hFFFF_FFFF, '1);
    drive(3'd0, 1'b0, 32'h0, '1);
    drive(3'd0, 1'b0, 32'h0, '1);
    chk("R8 no edge from held-high pin", 32'(bank_irq), 32'h0);
    chk("R8 no direct from held-high pin", 32'(direct_irq), 32'h0);
    // R2: falling edge with no fall enable after reset
    drive(3'd0, 1'b0, 32'h0, 64'h0);
    drive(3'd0, 1'b0, 32'h0, 64'h0);
    chk("R2 fall without enable", 32'(bank_irq), 32'h0);
    chk("R2 fall without enable direct", 32'(direct_irq), 32'h0);
    // R9 R7: rise on all of set 0
    drive(3'd0, 1'b0, 32'h0, 64'h0000_0000_FFFF_FFFF);
    chk("R7 direct all low pins", 32'(direct_irq), 32'h0000_00FF);
    chk("R9 bank lag", 32'(bank_irq), 32'h0);
    drive(3'd0, 1'b0, 32'h0, 64'h0000_0000_FFFF_FFFF);
    chk("R5 set0 halves", 32'(bank_irq), 32'h3);
    chk("R7 one-cycle pulse", 32'(direct_irq), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule